// File: doc/BRIEF.md
# Three-Word Test Vector Assembler

This block turns a stream of 32-bit words, taken from a first-word-fall-through input FIFO that runs at the memory-side clock, into 96-bit pin vectors for a tester. Three consecutive words make up one vector. Each finished vector goes out on a registered bus, one flip-flop per pin. A valid flag marks the bus while the vector is current.

Vectors come out at one third of the FIFO clock rate. This slow rate is modelled inside a single clock domain as an enable that fires on every third cycle. A vector can change, and the valid flag can change, only on that enable. The block reads one word per fast cycle, so a FIFO that never runs empty keeps a new vector on the pins in every slow period.

If the FIFO runs dry after streaming has begun, the block does not present a partly built vector. It keeps the last complete vector on the pins, drops the valid flag for that period and sets a sticky underrun flag. A run input starts and stops assembly. When the run input is low, no words are read and any partly collected words are thrown away.

Top module: `vecAssembler`

## Requirements
- R1: After reset, vecValid, underrunErr and fifoRd are 0 and every bit of vecOut is 0.
- R2: fifoRd is high only in a cycle where runEn is high and fifoEmpty is low. In that cycle the word on fifoData is taken and the FIFO pointer advances.
- R3: Within a vector, the first word taken fills bits 31:0, the second fills bits 63:32 and the third fills bits 95:64. Words are packed in the order they were read.
- R4: vecOut and vecValid change only at the slow enable, which fires on every third cycle counted from reset. A vector is presented, with vecValid high for a full slow period, only once all three of its words have been taken. With only two words available, vecValid stays 0.
- R5: While runEn is high and the FIFO never runs empty, a new vector is presented every 3 cycles and vecValid stays high between them.
- R6: If the current vector is incomplete at a slow enable after streaming has begun, vecValid is 0 for that period and vecOut keeps the last complete vector.
- R7: underrunErr is set by the condition in R6 and then stays set until reset. Incomplete assembly before the first vector of a run does not set it.
- R8: While runEn is low, no word is read. vecValid falls at the next slow enable. Words collected before runEn fell are discarded, so the next vector is built from the words read after runEn rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side (FIFO) clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Starts assembly when high, stops and flushes it when low |
| fifoData | input | 32 | Word at the head of the input FIFO (first-word fall-through) |
| fifoEmpty | input | 1 | Input FIFO has no word |
| fifoRd | output | 1 | Pops the head word this cycle |
| vecOut | output | 96 | Registered pin vector, one flop per pin |
| vecValid | output | 1 | vecOut holds a vector for the current slow period |
| underrunErr | output | 1 | Sticky: a slow period found the vector incomplete while streaming |

## Verification
The hardest case is the slow enable that falls in the same cycle as the first word of the next vector is read. If the design does not take that word into slot 0 while handing the full vector to the pins, the full-rate stream loses a word or falls to one vector every six cycles. The bench measures the gap between vectors and compares every vector word by word, so it catches a swapped slot order or a partial vector reaching the pins. Directed runs test four more cases: two words only, which a premature presenter would put out; a stop with words already collected, which a design without a flush would mix into the next vector; a dry FIFO after streaming, where the bus must hold and the error must latch; and a reset that must clear the error.

// File: rtl/vecAsmPkg.sv
package vecAsmPkg;
  // Width of the slot index carried in the strobe struct (up to 16 words per vector)
  localparam int SLOT_W = 4;

  typedef struct packed {
    logic              wrEn;    // store fifoData into a staging slot
    logic [SLOT_W-1:0] wrSlot;  // which slot receives the word
    logic              xfer;    // move staged vector to the pin flops, raise valid
    logic              drop;    // slow period without a vector: lower valid
  } asmStrobes_t;
endpackage

// File: rtl/vecAsmCtrl.sv
module vecAsmCtrl
  import vecAsmPkg::*;
#(
  parameter int WORDS = 3,
  parameter int DIV   = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        fifoEmpty,
  output logic        fifoRd,
  output logic        underrunErr,
  output asmStrobes_t strb
);
  localparam int PH_W  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CNT_W = $clog2(WORDS + 1);

  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] wordCnt;
  logic             streaming;
  logic             slowTick;
  logic             vecFull;
  logic             xferNow;

  assign slowTick = (phase == PH_W'(DIV - 1));
  assign vecFull  = (wordCnt == CNT_W'(WORDS));
  assign xferNow  = slowTick && runEn && vecFull;

  // A word can be taken while slots remain, or on the enable that empties them
  assign fifoRd = runEn && !fifoEmpty && (!vecFull || slowTick);

  always_comb begin
    strb        = '0;
    strb.wrEn   = fifoRd;
    strb.wrSlot = xferNow ? '0 : SLOT_W'(wordCnt);
    strb.xfer   = xferNow;
    strb.drop   = slowTick && !xferNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (slowTick) begin
      phase <= '0;
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !runEn) begin
      wordCnt <= '0;
    end else if (xferNow) begin
      wordCnt <= fifoRd ? CNT_W'(1) : '0;
    end else if (fifoRd) begin
      wordCnt <= wordCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !runEn) begin
      streaming <= 1'b0;
    end else if (xferNow) begin
      streaming <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      underrunErr <= 1'b0;
    end else if (slowTick && runEn && streaming && !vecFull) begin
      underrunErr <= 1'b1;
    end
  end
endmodule

// File: rtl/vecAsmData.sv
module vecAsmData
  import vecAsmPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WORDS  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [WORD_W-1:0]       fifoData,
  input  asmStrobes_t             strb,
  output logic [WORD_W*WORDS-1:0] vecOut,
  output logic                    vecValid
);
  localparam int VEC_W = WORD_W * WORDS;

  logic [VEC_W-1:0] staged;

  // One staging register per word slot; slot s sits at bits s*WORD_W upward
  for (genvar s = 0; s < WORDS; s++) begin : g_slot
    logic [WORD_W-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotQ <= '0;
      end else if (strb.wrEn && strb.wrSlot == SLOT_W'(s)) begin
        slotQ <= fifoData;
      end
    end
    assign staged[s*WORD_W +: WORD_W] = slotQ;
  end

  // A dedicated flop for each tester pin
  for (genvar p = 0; p < VEC_W; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rstN) begin
        vecOut[p] <= 1'b0;
      end else if (strb.xfer) begin
        vecOut[p] <= staged[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecValid <= 1'b0;
    end else if (strb.xfer) begin
      vecValid <= 1'b1;
    end else if (strb.drop) begin
      vecValid <= 1'b0;
    end
  end
endmodule

// File: rtl/vecAssembler.sv
module vecAssembler
  import vecAsmPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WORDS  = 3,
  parameter int DIV    = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    runEn,
  input  logic [WORD_W-1:0]       fifoData,
  input  logic                    fifoEmpty,
  output logic                    fifoRd,
  output logic [WORD_W*WORDS-1:0] vecOut,
  output logic                    vecValid,
  output logic                    underrunErr
);
  asmStrobes_t strb;

  vecAsmCtrl #(.WORDS(WORDS), .DIV(DIV)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .runEn      (runEn),
    .fifoEmpty  (fifoEmpty),
    .fifoRd     (fifoRd),
    .underrunErr(underrunErr),
    .strb       (strb)
  );

  vecAsmData #(.WORD_W(WORD_W), .WORDS(WORDS)) data_i (
    .clk     (clk),
    .rstN    (rstN),
    .fifoData(fifoData),
    .strb    (strb),
    .vecOut  (vecOut),
    .vecValid(vecValid)
  );
endmodule

// File: rtl/vecAssemblerChk.sv
module vecAssemblerChk #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 3,
  parameter int DIV    = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    runEn,
  input logic                    fifoEmpty,
  input logic                    fifoRd,
  input logic [WORD_W*WORDS-1:0] vecOut,
  input logic                    vecValid,
  input logic                    underrunErr
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;

  // Independent count of cycles since reset, modulo the slow ratio
  logic [PH_W-1:0] chkPhase;
  always_ff @(posedge clk) begin
    if (!rstN) chkPhase <= '0;
    else if (chkPhase == PH_W'(DIV - 1)) chkPhase <= '0;
    else chkPhase <= chkPhase + PH_W'(1);
  end

  // R2
  rd_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |-> (runEn && !fifoEmpty));

  // R8
  idle_no_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !fifoRd);

  // R4
  valid_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid != $past(vecValid)) |-> (chkPhase == '0));

  // R4
  vec_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecOut != $past(vecOut)) |-> (chkPhase == '0));

  // R6
  hold_when_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vecValid |-> $stable(vecOut));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    underrunErr |=> underrunErr);
endmodule

bind vecAssembler vecAssemblerChk #(.WORD_W(WORD_W), .WORDS(WORDS), .DIV(DIV)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .runEn      (runEn),
  .fifoEmpty  (fifoEmpty),
  .fifoRd     (fifoRd),
  .vecOut     (vecOut),
  .vecValid   (vecValid),
  .underrunErr(underrunErr)
);

// File: tb/vecAssembler_tb_top.sv
module vecAssembler_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic [31:0] fifoData;
  logic        fifoEmpty;
  logic        fifoRd;
  logic [95:0] vecOut;
  logic        vecValid;
  logic        underrunErr;

  always #2 clk = ~clk;   // 250 MHz

  vecAssembler dut_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .fifoData(fifoData),
    .fifoEmpty(fifoEmpty), .fifoRd(fifoRd), .vecOut(vecOut),
    .vecValid(vecValid), .underrunErr(underrunErr)
  );

  int checks = 0;
  int failures = 0;

  // ---------------- FIFO model ----------------
  logic [31:0] mem [0:2047];
  int  rdPtr = 0;
  int  wrLimit = 0;
  bit  ptrClr = 1'b1;
  bit  forceStarve = 1'b0;
  bit  randStarve = 1'b0;
  int  starvePct = 0;

  assign fifoEmpty = forceStarve || randStarve || (rdPtr >= wrLimit);
  assign fifoData  = mem[rdPtr[10:0]];

  always @(posedge clk) begin
    if (ptrClr) rdPtr <= 0;
    else if (fifoRd && !fifoEmpty) rdPtr <= rdPtr + 1;
  end

  always @(negedge clk) randStarve <= (starvePct > 0) && (($urandom % 100) < starvePct);

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic logic [95:0] expVec(input int base);
    return {mem[base+2], mem[base+1], mem[base]};
  endfunction

  // ---------------- scoreboard ----------------
  int          expIdx = 0;
  int          evtCount = 0;
  int          sinceEvt = 0;
  bit          haveEvt = 1'b0;
  bit          chkGap = 1'b0;
  bit          prevValid = 1'b0;
  logic [95:0] prevOut = '0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevValid = 1'b0;
      prevOut   = '0;
      haveEvt   = 1'b0;
      sinceEvt  = 0;
    end else begin
      sinceEvt++;
      if (vecValid && (!prevValid || vecOut != prevOut)) begin
        // R3: words packed in read order, lowest slot first
        check(vecOut == expVec(expIdx), "R3",
              $sformatf("vector %0d actual %h expected %h", evtCount, vecOut, expVec(expIdx)));
        // R5: full-rate stream gives one vector per three cycles
        if (chkGap && haveEvt)
          check(sinceEvt == 3 && prevValid, "R5",
                $sformatf("gap actual %0d expected 3 (prevValid %0b)", sinceEvt, prevValid));
        expIdx   += 3;
        evtCount++;
        sinceEvt  = 0;
        haveEvt   = 1'b1;
      end
      prevValid = vecValid;
      prevOut   = vecOut;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0; runEn = 1'b0; ptrClr = 1'b1; forceStarve = 1'b0;
    starvePct = 0; chkGap = 1'b0;
    cycles(3);
    expIdx = 0; evtCount = 0;
    ptrClr = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [95:0] held;
    int          startEvt;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2048; i++) mem[i] = {i[15:0], 16'($urandom)};

    doReset();
    @(negedge clk);
    check(vecValid == 0 && vecOut == '0 && underrunErr == 0, "R1",
          $sformatf("during reset valid %0b out %h err %0b expected 0", vecValid, vecOut, underrunErr));
    rstN = 1'b1;
    cycles(2);
    check(vecValid == 0 && underrunErr == 0 && fifoRd == 0, "R1",
          $sformatf("after reset valid %0b err %0b rd %0b expected 0", vecValid, underrunErr, fifoRd));

    // R8: words available but runEn low -> nothing read
    wrLimit = 20;
    cycles(12);
    check(rdPtr == 0, "R8", $sformatf("reads while idle actual %0d expected 0", rdPtr));
    check(vecValid == 0, "R8", $sformatf("valid while idle actual %0b expected 0", vecValid));

    // R4 / R7: only two words -> no vector, no underrun yet
    wrLimit = 2;
    runEn = 1'b1;
    cycles(12);
    check(rdPtr == 2, "R2", $sformatf("words taken actual %0d expected 2", rdPtr));
    check(vecValid == 0, "R4", $sformatf("valid with two words actual %0b expected 0", vecValid));
    check(underrunErr == 0, "R7", $sformatf("error before first vector actual %0b expected 0", underrunErr));

    // R8: stop flushes the two collected words
    runEn = 1'b0;
    cycles(6);
    expIdx = 2;
    wrLimit = 2000;
    chkGap = 1'b1;
    runEn = 1'b1;
    startEvt = evtCount;
    for (int t = 0; t < 400 && evtCount < startEvt + 40; t++) cycles(1);
    check(evtCount >= startEvt + 40, "R5", $sformatf("vectors actual %0d expected 40", evtCount - startEvt));
    check(underrunErr == 0, "R7", $sformatf("error on full-rate stream actual %0b expected 0", underrunErr));
    check(vecValid == 1, "R5", $sformatf("valid during stream actual %0b expected 1", vecValid));

    // R6 / R7: FIFO runs dry after streaming started
    chkGap = 1'b0;
    forceStarve = 1'b1;
    cycles(9);
    held = vecOut;
    check(held == expVec(expIdx - 3), "R6",
          $sformatf("held vector actual %h expected %h", held, expVec(expIdx - 3)));
    cycles(6);
    check(vecValid == 0, "R6", $sformatf("valid on underrun actual %0b expected 0", vecValid));
    check(vecOut == held, "R6", $sformatf("vector not held actual %h expected %h", vecOut, held));
    check(underrunErr == 1, "R7", $sformatf("underrun flag actual %0b expected 1", underrunErr));

    // Random starvation, scoreboard checks content
    forceStarve = 1'b0;
    starvePct = 35;
    startEvt = evtCount;
    cycles(600);
    starvePct = 0;
    check(evtCount > startEvt + 20, "R3", $sformatf("vectors under random starve actual %0d expected >20", evtCount - startEvt));
    check(underrunErr == 1, "R7", $sformatf("flag cleared without reset actual %0b expected 1", underrunErr));

    // R8: stop lowers valid at next slow period
    runEn = 1'b0;
    cycles(6);
    check(vecValid == 0, "R8", $sformatf("valid after stop actual %0b expected 0", vecValid));
    check(fifoRd == 0, "R8", $sformatf("read after stop actual %0b expected 0", fifoRd));

    // R7: reset clears the flag
    doReset();
    rstN = 1'b1;
    cycles(2);
    check(underrunErr == 0 && vecValid == 0, "R7",
          $sformatf("after reset err %0b valid %0b expected 0", underrunErr, vecValid));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule